// File: doc/BRIEF.md
# Multi-Cycle 16-Bit Instruction Sequencer

This block is the control and datapath core of a small 16-bit processor. It takes each instruction through a fixed series of phases: fetch, decode, evaluate address, fetch data, execute and store result. Any phase that the current opcode does not need is skipped. It holds a program counter, an instruction register, a memory address register (MAR), a memory data register (MDR), eight general registers and a set of three condition flags. It executes register-mode add, bitwise AND, bitwise NOT, PC-relative load and store, and a conditional branch.

All memory traffic goes through MAR and MDR to one external single-port word memory. The core raises a request and waits for a one-cycle ready pulse, so a memory access lasts as many cycles as the memory takes. Phases that do not touch memory take exactly one cycle. In a system, the core is connected to a memory model or a memory controller, and it starts running from a parameterised start address when synchronous reset is released.

Top module: `seq16_core`

## Requirements
- R1: In the fetch phase the PC is copied to MAR, the word at that address is read into MDR and then moved to the instruction register, and the PC advances by one. Bits [15:12] are the opcode and bits [11:0] are the operand fields.
- R2: A memory request keeps `mem_req` high with address, write flag and write data unchanged until the cycle in which `mem_ready` is high. In the cycle after that, the request is dropped.
- R3: Opcode 0001 with bits [5:3] = 000 writes SR1 ([8:6]) + SR2 ([2:0]) modulo 2^16 to DR ([11:9]).
- R4: Opcode 0101 with bits [5:3] = 000 writes the bitwise AND of SR1 and SR2 to DR.
- R5: Opcode 1001 with bits [5:0] = 111111 writes the bitwise complement of SR ([8:6]) to DR ([11:9]).
- R6: Opcode 0010 reads memory at (incremented PC + sign-extended [8:0]) and writes the word to the register in [11:9].
- R7: Opcode 0011 writes the register in [11:9] to memory at (incremented PC + sign-extended [8:0]).
- R8: Add, AND, NOT and load set exactly one flag, from the value written: negative when bit 15 is set, zero when the value is zero, positive otherwise. Store, branch and no-ops leave the flags unchanged.
- R9: Opcode 0000 with mask bits n = [11], z = [10], p = [9] is taken when any masked flag is set. The new PC is then the incremented PC + sign-extended [8:0], and forward and backward offsets both work.
- R10: Synchronous active-low reset sets the PC to the start address (default 0x3000), sets the zero flag and clears all eight registers.
- R11: With a memory latency of L cycles, the time from the start of one fetch request to the start of the next is L+5 for add/AND/NOT, 2L+5 for a load, 2L+4 for a store, L+4 for a branch and L+3 for a no-op.
- R12: Undefined opcodes, add/AND with [5:3] other than 000, and NOT with [5:0] other than 111111 are no-ops. They change no register and no flag, and the core returns to fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_req | output | 1 | Memory access in progress |
| mem_we | output | 1 | Access is a write when high |
| mem_addr | output | 16 | Word address (MAR) |
| mem_wdata | output | 16 | Write data (MDR) |
| mem_rdata | input | 16 | Read data, sampled in the ready cycle |
| mem_ready | input | 1 | Access completes in this cycle |

## Verification
Each of eight operand values is paired with each of the eight values to run add, AND and NOT together with both loads. This includes sign-boundary and all-zero/all-ones words, which tell apart carry-out dropping, sign handling and a wrong source field. A follow-up branch, placed after a store and run with all eight masks, shows whether the flags came from the last result or were disturbed by the store. A second sweep puts a no-op, an add, a malformed add, a malformed NOT or an AND between a load and a branch, which shows whether each one updates or preserves flags and registers. Phase timing is measured from the spacing of fetch requests at latencies of 1, 3 and 100 cycles, which separates a correct skipped phase from an extra or missing cycle.

// File: rtl/seq16_pkg.sv
// Shared encodings for the 16-bit sequencer.
// Assumes 3-bit register fields, so the register file holds eight entries.
package seq16_pkg;
    localparam int RF_W = 3;
    localparam int CC_N = 2;
    localparam int CC_Z = 1;
    localparam int CC_P = 0;

    localparam logic [3:0] OPC_BR  = 4'b0000;
    localparam logic [3:0] OPC_ADD = 4'b0001;
    localparam logic [3:0] OPC_LD  = 4'b0010;
    localparam logic [3:0] OPC_ST  = 4'b0011;
    localparam logic [3:0] OPC_AND = 4'b0101;
    localparam logic [3:0] OPC_NOT = 4'b1001;

    typedef enum logic [3:0] {
        PH_FADDR, PH_FMEM, PH_FIR, PH_DEC, PH_EVAL,
        PH_FDATA, PH_EXEC, PH_STORE, PH_WMEM
    } phase_e;

    typedef enum logic [1:0] {ALU_ADD, ALU_AND, ALU_NOT} alu_op_e;
endpackage

// File: rtl/seq16_regfile.sv
// General register file: two combinational read ports, one write port.
// Assumes NREG is a power of two. Reset clears every entry.
module seq16_regfile #(
    parameter int W    = 16,
    parameter int NREG = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(NREG)-1:0]  waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(NREG)-1:0]  raddr_a,
    input  logic [$clog2(NREG)-1:0]  raddr_b,
    output logic [W-1:0]             rdata_a,
    output logic [W-1:0]             rdata_b
);
    logic [W-1:0] regs [NREG];

    // Write port: clear on reset, otherwise update the addressed entry.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (we && (waddr == i[$clog2(NREG)-1:0]))
                regs[i] <= wdata;
        end
    end

    // Read ports: plain array lookup.
    always_comb begin
        rdata_a = regs[raddr_a];
        rdata_b = regs[raddr_b];
    end
endmodule

// File: rtl/seq16_alu.sv
// Operate unit: add, AND, NOT on two register operands. Purely combinational.
module seq16_alu
    import seq16_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    // Select the result of the requested operation.
    always_comb begin
        case (op)
            ALU_AND: y = a & b;
            ALU_NOT: y = ~a;
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/seq16_flags.sv
// Classifies a write-back value as negative, zero or positive (one-hot).
module seq16_flags
    import seq16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    output logic [2:0]   nzp
);
    // Sign bit and zero test give the three flags.
    always_comb begin
        nzp         = '0;
        nzp[CC_N]   = val[W-1];
        nzp[CC_Z]   = (val == '0);
        nzp[CC_P]   = !val[W-1] && (val != '0);
    end
endmodule

// File: rtl/seq16_ctrl.sv
// Phase sequencer and architectural state (PC, IR, MAR, MDR, flags).
// Each phase without memory takes one cycle; memory phases wait for ready.
// Assumes the memory never signals ready without an active request.
module seq16_ctrl
    import seq16_pkg::*;
#(
    parameter int           W     = 16,
    parameter logic [W-1:0] START = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mem_ready,
    input  logic [W-1:0]     mem_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [W-1:0]     mem_addr,
    output logic [W-1:0]     mem_wdata,
    output logic             rf_we,
    output logic [RF_W-1:0]  rf_waddr,
    output logic [W-1:0]     rf_wdata,
    output logic [RF_W-1:0]  rf_raddr_a,
    output logic [RF_W-1:0]  rf_raddr_b,
    input  logic [W-1:0]     rf_rdata_a,
    output alu_op_e          alu_op,
    input  logic [W-1:0]     alu_y,
    input  logic [2:0]       wb_nzp
);
    phase_e       ph;
    logic [W-1:0] pc, ir, mar, mdr, res;
    logic [2:0]   cc;
    logic [3:0]   opc;
    logic [W-1:0] off_ext, pc_off;
    logic         alu_ok, br_take;

    // Field decode of the current instruction.
    always_comb begin
        opc     = ir[15:12];
        off_ext = {{(W-9){ir[8]}}, ir[8:0]};
        pc_off  = pc + off_ext;
        alu_ok  = (((opc == OPC_ADD) || (opc == OPC_AND)) && (ir[5:3] == 3'b000))
                || ((opc == OPC_NOT) && (ir[5:0] == 6'b111111));
        br_take = |(ir[11:9] & cc);
    end

    // Register file, operate unit and memory bus controls.
    always_comb begin
        rf_raddr_a = (opc == OPC_ST) ? ir[11:9] : ir[8:6];
        rf_raddr_b = ir[2:0];
        rf_waddr   = ir[11:9];
        rf_we      = (ph == PH_STORE);
        rf_wdata   = (opc == OPC_LD) ? mdr : res;
        case (opc)
            OPC_AND: alu_op = ALU_AND;
            OPC_NOT: alu_op = ALU_NOT;
            default: alu_op = ALU_ADD;
        endcase
        mem_req   = (ph == PH_FMEM) || (ph == PH_FDATA) || (ph == PH_WMEM);
        mem_we    = (ph == PH_WMEM);
        mem_addr  = mar;
        mem_wdata = mdr;
    end

    // Phase stepping and architectural register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= PH_FADDR;
            pc  <= START;
            ir  <= '0;
            mar <= '0;
            mdr <= '0;
            res <= '0;
            cc  <= 3'b010;
        end else begin
            case (ph)
                PH_FADDR: begin
                    mar <= pc;
                    pc  <= pc + W'(1);
                    ph  <= PH_FMEM;
                end
                PH_FMEM: if (mem_ready) begin
                    mdr <= mem_rdata;
                    ph  <= PH_FIR;
                end
                PH_FIR: begin
                    ir <= mdr;
                    ph <= PH_DEC;
                end
                PH_DEC: begin
                    case (opc)
                        OPC_ADD, OPC_AND, OPC_NOT: ph <= alu_ok ? PH_EXEC : PH_FADDR;
                        OPC_LD, OPC_ST:            ph <= PH_EVAL;
                        OPC_BR:                    ph <= PH_EXEC;
                        default:                   ph <= PH_FADDR;
                    endcase
                end
                PH_EVAL: begin
                    mar <= pc_off;
                    if (opc == OPC_ST) begin
                        mdr <= rf_rdata_a;
                        ph  <= PH_WMEM;
                    end else begin
                        ph  <= PH_FDATA;
                    end
                end
                PH_FDATA: if (mem_ready) begin
                    mdr <= mem_rdata;
                    ph  <= PH_STORE;
                end
                PH_EXEC: begin
                    if (opc == OPC_BR) begin
                        if (br_take) pc <= pc_off;
                        ph <= PH_FADDR;
                    end else begin
                        res <= alu_y;
                        ph  <= PH_STORE;
                    end
                end
                PH_STORE: begin
                    cc <= wb_nzp;
                    ph <= PH_FADDR;
                end
                PH_WMEM: if (mem_ready) ph <= PH_FADDR;
                default: ph <= PH_FADDR;
            endcase
        end
    end

    // R1: leaving the fetch-address phase advances the PC by one.
    a_r1_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_FADDR) |=> (pc == $past(pc) + W'(1)));

    // R8: exactly one flag is set at all times.
    a_r8_cc_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cc) == 1);

    // R8: flags only move after a register write-back phase.
    a_r8_cc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != PH_STORE) |=> $stable(cc));

    // R12: a malformed operate instruction goes straight back to fetch.
    a_r12_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_DEC && !alu_ok &&
         (opc == OPC_ADD || opc == OPC_AND || opc == OPC_NOT))
        |=> (ph == PH_FADDR));
endmodule

// File: rtl/seq16_core.sv
// Top of the multi-cycle sequencer: wires phase control, register file,
// operate unit and flag classifier to one external word memory.
// Assumes the memory answers each request with a one-cycle ready pulse.
module seq16_core
    import seq16_pkg::*;
#(
    parameter int           W     = 16,
    parameter int           NREG  = 8,
    parameter logic [W-1:0] START = 16'h3000
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          mem_req,
    output logic          mem_we,
    output logic [W-1:0]  mem_addr,
    output logic [W-1:0]  mem_wdata,
    input  logic [W-1:0]  mem_rdata,
    input  logic          mem_ready
);
    logic            rf_we;
    logic [RF_W-1:0] rf_waddr, rf_raddr_a, rf_raddr_b;
    logic [W-1:0]    rf_wdata, rf_rdata_a, rf_rdata_b, alu_y;
    logic [2:0]      wb_nzp;
    alu_op_e         alu_op;

    seq16_ctrl #(.W(W), .START(START)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .rf_raddr_a(rf_raddr_a), .rf_raddr_b(rf_raddr_b),
        .rf_rdata_a(rf_rdata_a),
        .alu_op(alu_op), .alu_y(alu_y), .wb_nzp(wb_nzp)
    );

    seq16_regfile #(.W(W), .NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
        .raddr_a(rf_raddr_a), .raddr_b(rf_raddr_b),
        .rdata_a(rf_rdata_a), .rdata_b(rf_rdata_b)
    );

    seq16_alu #(.W(W)) u_alu (
        .op(alu_op), .a(rf_rdata_a), .b(rf_rdata_b), .y(alu_y)
    );

    seq16_flags #(.W(W)) u_flags (
        .val(rf_wdata), .nzp(wb_nzp)
    );

    // R2: an open request holds its address, direction and data.
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R2: a completed request is withdrawn in the next cycle.
    a_r2_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> !mem_req);
endmodule

// File: tb/test_seq16_core.sv
// Bench: a latency-configurable word memory model, programs built from
// encoder functions, and expected values computed from operand arithmetic.
module test_seq16_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req, mem_we, mem_ready;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;

    int vectors = 0;
    int miscompares = 0;

    logic [15:0] mem  [256];
    logic [15:0] wdat [256];
    logic [255:0] wflag;
    int   lat = 2;
    int   cnt = 0;
    int   ncyc = 0;
    bit   pend = 0, done_prev = 0, prev_req = 0;
    logic [15:0] h_addr, h_wd;
    logic        h_we;
    int   hold_bad = 0;
    int   rec_t [64];
    logic [15:0] rec_a [64];
    int   nrec = 0;

    always #5 clk = ~clk;

    seq16_core i_seq16_core (
        .clk(clk), .rst_n(rst_n),
        .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    assign mem_ready = mem_req && (cnt == lat);
    assign mem_rdata = mem[mem_addr[7:0]];

    // Memory model, evaluated mid-cycle: latency count, writes, handshake watch.
    always @(negedge clk) begin
        ncyc++;
        if (!rst_n) begin
            cnt = 0; pend = 0; done_prev = 0; prev_req = 0;
        end else begin
            if (pend && (!mem_req || mem_addr != h_addr || mem_we != h_we ||
                         (mem_we && mem_wdata != h_wd))) hold_bad++;
            if (done_prev && mem_req) hold_bad++;
            if (mem_req && !prev_req && !mem_we && mem_addr[7:0] < 8'h40 && nrec < 64) begin
                rec_t[nrec] = ncyc;
                rec_a[nrec] = mem_addr;
                nrec++;
            end
            if (mem_req) cnt++; else cnt = 0;
            done_prev = mem_req && (cnt == lat);
            pend      = mem_req && (cnt < lat);
            if (done_prev && mem_we) begin
                mem[mem_addr[7:0]]  = mem_wdata;
                wdat[mem_addr[7:0]] = mem_wdata;
                wflag[mem_addr[7:0]] = 1'b1;
            end
            h_addr = mem_addr; h_we = mem_we; h_wd = mem_wdata;
            prev_req = mem_req;
        end
    end

    function automatic logic [15:0] enc_rr(logic [3:0] opc, int dr, int s1, int s2);
        return {opc, 3'(dr), 3'(s1), 3'b000, 3'(s2)};
    endfunction
    function automatic logic [15:0] enc_not(int dr, int s);
        return {4'b1001, 3'(dr), 3'(s), 6'h3F};
    endfunction
    function automatic logic [15:0] enc_pc(logic [3:0] opc, int r, int k, int t);
        return {opc, 3'(r), 9'(t - k - 1)};
    endfunction
    function automatic logic [2:0] nzp_of(logic [15:0] v);
        if (v[15]) return 3'b100;
        if (v == 16'h0) return 3'b010;
        return 3'b001;
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wipe();
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 256; i++) mem[i] = 16'hF000;
        wflag = '0;
        nrec = 0;
    endtask

    // Release reset and run until the end marker (word 0x5F) is written.
    task automatic run(int l);
        bit fin = 0;
        lat = l;
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 8000 && !fin; c++) begin
            @(posedge clk);
            if (wflag[8'h5F]) fin = 1;
        end
        @(negedge clk);
        rst_n = 1'b0;
        if (!fin) check("R1 program reached end marker", 16'h0, 16'h1);
    endtask

    localparam logic [15:0] VALS [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                                         16'hFFFF, 16'h1234, 16'hA5A5, 16'h0F0F};

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : stim
        logic [15:0] a, b, x;
        logic [2:0] m, ccx;
        repeat (3) @(negedge clk);

        // R10 / R1: reset state observed through a leading branch.
        for (int mk = 0; mk < 8; mk++) begin
            wipe();
            mem[0] = enc_pc(4'b0000, mk, 0, 2);
            mem[1] = enc_pc(4'b0011, 0, 1, 8'h53);
            mem[2] = enc_pc(4'b0011, 3, 2, 8'h5F);
            run(2);
            check("R10 reset flag z drives branch", {15'h0, !wflag[8'h53]}, {15'h0, mk[1]});
            check("R10 registers cleared", wdat[8'h5F], 16'h0000);
            check("R1 first fetch at start address", rec_a[0], 16'h3000);
        end

        // R3 R4 R5 R6 R7 R9 R8: operand sweep.
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                a = VALS[i]; b = VALS[j]; m = 3'(i + j);
                wipe();
                mem[8'h40] = a; mem[8'h41] = b;
                mem[0]  = enc_pc(4'b0010, 1, 0, 8'h40);
                mem[1]  = enc_pc(4'b0010, 2, 1, 8'h41);
                mem[2]  = enc_rr(4'b0001, 3, 1, 2);
                mem[3]  = enc_pc(4'b0011, 3, 3, 8'h50);
                mem[4]  = enc_rr(4'b0101, 4, 1, 2);
                mem[5]  = enc_pc(4'b0011, 4, 5, 8'h51);
                mem[6]  = enc_not(5, 1);
                mem[7]  = enc_pc(4'b0011, 5, 7, 8'h52);
                mem[8]  = enc_pc(4'b0000, m, 8, 10);
                mem[9]  = enc_pc(4'b0011, 1, 9, 8'h53);
                mem[10] = enc_pc(4'b0011, 2, 10, 8'h5F);
                run(2);
                check("R3 add result", wdat[8'h50], a + b);
                check("R4 and result", wdat[8'h51], a & b);
                check("R5 not result", wdat[8'h52], ~a);
                check("R6 load into register", wdat[8'h5F], b);
                check("R7 store reached target", {15'h0, wflag[8'h50]}, 16'h1);
                check("R9 branch after store uses NOT flags",
                      {15'h0, !wflag[8'h53]}, {15'h0, |(m & nzp_of(~a))});
            end
        end

        // R8 R12: flag behaviour of an instruction between load and branch.
        for (int v = 0; v < 5; v++) begin
            for (int i = 0; i < 8; i++) begin
                for (int mk = 0; mk < 8; mk++) begin
                    a = VALS[i]; m = 3'(mk);
                    case (v)
                        0: begin x = 16'hF000;                          ccx = nzp_of(a); end
                        1: begin x = enc_rr(4'b0001, 2, 1, 1);          ccx = nzp_of(a + a); end
                        2: begin x = {4'b0001, 3'd1, 3'd1, 6'b100001};  ccx = nzp_of(a); end
                        3: begin x = {4'b1001, 3'd1, 3'd1, 6'b111110};  ccx = nzp_of(a); end
                        default: begin x = enc_rr(4'b0101, 2, 1, 0);    ccx = 3'b010; end
                    endcase
                    wipe();
                    mem[8'h40] = a;
                    mem[0] = enc_pc(4'b0010, 1, 0, 8'h40);
                    mem[1] = x;
                    mem[2] = enc_pc(4'b0000, mk, 2, 4);
                    mem[3] = enc_pc(4'b0011, 1, 3, 8'h53);
                    mem[4] = enc_pc(4'b0011, 1, 4, 8'h5F);
                    run(2);
                    check("R8 flags seen by branch", {15'h0, !wflag[8'h53]},
                          {15'h0, |(m & ccx)});
                    check("R12 register unchanged by no-op or malformed op",
                          wdat[8'h5F], a);
                end
            end
        end

        // R9: forward then backward branch.
        wipe();
        mem[0] = enc_pc(4'b0000, 7, 0, 5);
        mem[5] = enc_pc(4'b0000, 7, 5, 3);
        mem[3] = enc_pc(4'b0011, 0, 3, 8'h5F);
        mem[1] = enc_pc(4'b0011, 0, 1, 8'h60);
        mem[2] = enc_pc(4'b0011, 0, 2, 8'h60);
        mem[4] = enc_pc(4'b0011, 0, 4, 8'h60);
        run(3);
        check("R9 backward branch target", {15'h0, wflag[8'h60]}, 16'h0);
        check("R9 fetch order 0,5,3", rec_a[2], 16'h3003);

        // R11: phase timing from fetch request spacing.
        foreach (VALS[li]) begin
            int l;
            if (li > 2) break;
            l = (li == 0) ? 1 : (li == 1) ? 3 : 100;
            wipe();
            mem[8'h40] = 16'h0005;
            mem[0] = enc_rr(4'b0001, 1, 1, 1);
            mem[1] = enc_pc(4'b0010, 2, 1, 8'h40);
            mem[2] = enc_pc(4'b0011, 2, 2, 8'h50);
            mem[3] = enc_pc(4'b0000, 0, 3, 4);
            mem[4] = 16'hF000;
            mem[5] = enc_rr(4'b0101, 3, 2, 2);
            mem[6] = enc_pc(4'b0011, 3, 6, 8'h5F);
            run(l);
            check("R11 add cycles",   16'(rec_t[1] - rec_t[0]), 16'(l + 5));
            check("R11 load cycles",  16'(rec_t[2] - rec_t[1]), 16'(2 * l + 5));
            check("R11 store cycles", 16'(rec_t[3] - rec_t[2]), 16'(2 * l + 4));
            check("R11 branch cycles", 16'(rec_t[4] - rec_t[3]), 16'(l + 4));
            check("R11 no-op cycles", 16'(rec_t[5] - rec_t[4]), 16'(l + 3));
            check("R11 and cycles",   16'(rec_t[6] - rec_t[5]), 16'(l + 5));
        end

        check("R2 request held until ready and dropped after", 16'(hold_bad), 16'h0);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule